// File: doc/BRIEF.md
# Microcode Operand Decoder

The decoder takes one 64-bit microcode instruction word and splits it into a 12-bit opcode and three operand fields: two sources and one destination. Each source operand is classified by its prefix and then resolved. A resolved source is one of three things: a word address for memory operands, a sign-extended 16-bit value for immediates, or a register index for register operands. The destination field is passed through unchanged, so the execution stage can interpret it for each opcode, for example as a jump target.

The parameter `OPND_W` selects the operand width: 12 bits (the default) or 13 bits. Both widths use the same prefixes, and only the variable tails grow. The word is packed from the top as zero padding, then the opcode, then x, y and z. The padding is 16 bits wide for 12-bit operands and 13 bits wide for 13-bit operands. All addresses are in 16-bit word units, so a byte offset of 2 is word address 1.

Six base-register values are supplied on an input bus. The decoder adds them to base-relative offsets. It also raises error flags for rule violations: two memory sources, two register-access sources, a reserved operand code, or nonzero padding. Results are registered and appear one clock after the input strobe, together with an output strobe.

Top module: `mc_operand_decoder`

## Requirements
- R1: The opcode is word bits [3W+11:3W], x is [3W-1:2W], y is [2W-1:W] and z is [W-1:0], with W = `OPND_W`. The opcode and the raw z field appear on `out_opcode` and `out_z_fld`.
- R2: A source whose top bit is 0 has kind 0 (direct memory), and its value is the remaining W-1 bits, zero-extended.
- R3: A source with top bits `11` has kind 4 (immediate). Its value is the low W-2 bits sign-extended to 16 bits, so 10'h3FF gives 16'hFFFF and 10'h200 gives 16'hFE00 when W = 12.
- R4: A source with top bits `100` has kind 2 (register access), and its value is the low W-3 bits, zero-extended.
- R5: A source with top bits `101` carries a 3-bit selector r in bits [W-4:W-6] and a (W-6)-bit offset. When r is 0 to 5, the kind is 1 (base-relative memory) and the value is base r plus the offset, modulo 2^16. Base r is `in_bases[16r+15:16r]`.
- R6: Selector 7 (top bits `101111`) gives kind 3 (CPU register) with the offset bits as the index. Selector 6 (top bits `101110`) is reserved: it gives kind 5 with value 0 and raises `out_err_enc`. Nonzero padding above the opcode also raises `out_err_enc`.
- R7: When both sources have kind 0 or kind 1, `out_err_mem` is raised.
- R8: When both sources have kind 2, `out_err_hw` is raised.
- R9: `out_valid` is `in_valid` delayed by one clock. `out_error` is the OR of the three cause flags. All error flags are 0 whenever `out_valid` is 0.
- R10: While reset is applied, and until the internal reset synchronizer releases, `out_valid` and every error flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word strobe |
| in_word | input | 64 | Microcode instruction word |
| in_bases | input | 96 | Six 16-bit base registers; base r at bits [16r+15:16r] |
| out_valid | output | 1 | Decoded result strobe |
| out_opcode | output | 12 | Opcode field |
| out_x_kind | output | 3 | Kind of source x (0 to 5, as in R2 to R6) |
| out_x_val | output | 16 | Resolved value of source x |
| out_y_kind | output | 3 | Kind of source y |
| out_y_val | output | 16 | Resolved value of source y |
| out_z_fld | output | OPND_W | Raw destination field |
| out_err_mem | output | 1 | More than one memory source |
| out_err_hw | output | 1 | More than one register-access source |
| out_err_enc | output | 1 | Reserved operand code or nonzero padding |
| out_error | output | 1 | Any error cause |

## Verification
Every decoded field and every error flag is due exactly one rising edge after the input strobe that carried the word. The data path contains no other register. The driver applies a word at a falling edge and queues the expected result. The monitor compares at the next falling edge where `out_valid` is high, so back-to-back words are checked in order with no gap. Idle cycles are checked at the falling edge one full clock after the strobe drops, which is where the strobe and the error flags must read 0.

// File: rtl/mcod_pkg.sv
package mcod_pkg;
  localparam int WORD_W   = 64;
  localparam int OPC_W    = 12;
  localparam int DATA_W   = 16;
  localparam int NUM_BASE = 6;
  localparam int KIND_W   = 3;

  typedef enum logic [KIND_W-1:0] {
    K_DMEM   = 3'd0,
    K_BMEM   = 3'd1,
    K_HWREG  = 3'd2,
    K_CPUREG = 3'd3,
    K_IMM    = 3'd4,
    K_BAD    = 3'd5
  } opnd_kind_e;
endpackage

// File: rtl/mcod_split.sv
module mcod_split
  import mcod_pkg::*;
#(
  parameter int OPND_W = 12
) (
  input  logic [WORD_W-1:0] word,
  output logic [OPC_W-1:0]  opcode,
  output logic [OPND_W-1:0] fx,
  output logic [OPND_W-1:0] fy,
  output logic [OPND_W-1:0] fz,
  output logic              pad_nz
);
  localparam int PAD_W = WORD_W - OPC_W - 3*OPND_W;

  // Fields packed from the top: padding, opcode, x, y, z
  assign opcode = word[3*OPND_W +: OPC_W];
  assign fx     = word[2*OPND_W +: OPND_W];
  assign fy     = word[OPND_W   +: OPND_W];
  assign fz     = word[0        +: OPND_W];
  assign pad_nz = |word[WORD_W-1 -: PAD_W];
endmodule

// File: rtl/mcod_classify.sv
module mcod_classify
  import mcod_pkg::*;
#(
  parameter int OPND_W = 12
) (
  input  logic [OPND_W-1:0]          fld,
  input  logic [NUM_BASE*DATA_W-1:0] bases,
  output opnd_kind_e                 kind,
  output logic [DATA_W-1:0]          val
);
  localparam int DIR_W = OPND_W - 1;
  localparam int IMM_W = OPND_W - 2;
  localparam int HW_W  = OPND_W - 3;
  localparam int OFS_W = OPND_W - 6;
  localparam int SEL_W = 3;

  logic [SEL_W-1:0]  sel;
  logic [OFS_W-1:0]  ofs;
  logic [DATA_W-1:0] base_val;

  assign sel = fld[OPND_W-4 -: SEL_W];
  assign ofs = fld[OFS_W-1:0];

  // Base mux; selectors 6 and 7 never reach the adder
  always_comb begin
    base_val = '0;
    for (int i = 0; i < NUM_BASE; i++) begin
      if (int'(sel) == i) base_val = bases[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    kind = K_BAD;
    val  = '0;
    if (!fld[OPND_W-1]) begin
      kind = K_DMEM;
      val  = DATA_W'(fld[DIR_W-1:0]);
    end else if (fld[OPND_W-2]) begin
      kind = K_IMM;
      val  = {{(DATA_W-IMM_W){fld[IMM_W-1]}}, fld[IMM_W-1:0]};
    end else if (!fld[OPND_W-3]) begin
      kind = K_HWREG;
      val  = DATA_W'(fld[HW_W-1:0]);
    end else if (int'(sel) < NUM_BASE) begin
      kind = K_BMEM;
      val  = base_val + DATA_W'(ofs);
    end else if (sel == '1) begin
      kind = K_CPUREG;
      val  = DATA_W'(ofs);
    end
  end
endmodule

// File: rtl/mcod_limits.sv
module mcod_limits
  import mcod_pkg::*;
(
  input  opnd_kind_e kind_x,
  input  opnd_kind_e kind_y,
  input  logic       pad_nz,
  output logic       err_mem,
  output logic       err_hw,
  output logic       err_enc
);
  logic mem_x, mem_y;

  assign mem_x   = (kind_x == K_DMEM) || (kind_x == K_BMEM);
  assign mem_y   = (kind_y == K_DMEM) || (kind_y == K_BMEM);
  assign err_mem = mem_x && mem_y;
  assign err_hw  = (kind_x == K_HWREG) && (kind_y == K_HWREG);
  assign err_enc = pad_nz || (kind_x == K_BAD) || (kind_y == K_BAD);
endmodule

// File: rtl/mc_operand_decoder.sv
module mc_operand_decoder
  import mcod_pkg::*;
#(
  parameter int OPND_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [WORD_W-1:0]          in_word,
  input  logic [NUM_BASE*DATA_W-1:0] in_bases,
  output logic                       out_valid,
  output logic [OPC_W-1:0]           out_opcode,
  output logic [KIND_W-1:0]          out_x_kind,
  output logic [DATA_W-1:0]          out_x_val,
  output logic [KIND_W-1:0]          out_y_kind,
  output logic [DATA_W-1:0]          out_y_val,
  output logic [OPND_W-1:0]          out_z_fld,
  output logic                       out_err_mem,
  output logic                       out_err_hw,
  output logic                       out_err_enc,
  output logic                       out_error
);
  localparam int NUM_SRC = 2;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // Field split
  logic [OPC_W-1:0]  opcode;
  logic [OPND_W-1:0] fz;
  logic [OPND_W-1:0] src_fld [NUM_SRC];
  logic              pad_nz;

  mcod_split #(.OPND_W(OPND_W)) u_split (
    .word   (in_word),
    .opcode (opcode),
    .fx     (src_fld[0]),
    .fy     (src_fld[1]),
    .fz     (fz),
    .pad_nz (pad_nz)
  );

  // One classifier per source operand
  opnd_kind_e        src_kind [NUM_SRC];
  logic [DATA_W-1:0] src_val  [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    mcod_classify #(.OPND_W(OPND_W)) u_cls (
      .fld   (src_fld[g]),
      .bases (in_bases),
      .kind  (src_kind[g]),
      .val   (src_val[g])
    );
  end

  logic err_mem, err_hw, err_enc;

  mcod_limits u_lim (
    .kind_x  (src_kind[0]),
    .kind_y  (src_kind[1]),
    .pad_nz  (pad_nz),
    .err_mem (err_mem),
    .err_hw  (err_hw),
    .err_enc (err_enc)
  );

  // Next-state
  logic [3:0] err_d, err_q;
  logic       valid_q;
  logic [OPC_W-1:0]  opc_q;
  logic [KIND_W-1:0] xk_q, yk_q;
  logic [DATA_W-1:0] xv_q, yv_q;
  logic [OPND_W-1:0] z_q;
  logic              data_en;

  assign data_en = in_valid;

  always_comb begin
    err_d = '0;
    if (in_valid) err_d = {err_mem | err_hw | err_enc, err_enc, err_hw, err_mem};
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      err_q   <= '0;
    end else begin
      valid_q <= in_valid;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      opc_q <= '0;
      xk_q  <= '0;
      yk_q  <= '0;
      xv_q  <= '0;
      yv_q  <= '0;
      z_q   <= '0;
    end else if (data_en) begin
      opc_q <= opcode;
      xk_q  <= src_kind[0];
      yk_q  <= src_kind[1];
      xv_q  <= src_val[0];
      yv_q  <= src_val[1];
      z_q   <= fz;
    end
  end

  assign out_valid   = valid_q;
  assign out_opcode  = opc_q;
  assign out_x_kind  = xk_q;
  assign out_x_val   = xv_q;
  assign out_y_kind  = yk_q;
  assign out_y_val   = yv_q;
  assign out_z_fld   = z_q;
  assign out_err_mem = err_q[0];
  assign out_err_hw  = err_q[1];
  assign out_err_enc = err_q[2];
  assign out_error   = err_q[3];
endmodule

// File: rtl/mcod_chk.sv
module mcod_chk #(
  parameter int OPND_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [OPND_W-1:0] x_fld,
  input logic [OPND_W-1:0] y_fld,
  input logic              out_valid,
  input logic [2:0]        out_x_kind,
  input logic              out_err_mem,
  input logic              out_err_hw,
  input logic              out_err_enc,
  input logic              out_error
);
  assert_valid_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_error && !out_err_mem && !out_err_hw && !out_err_enc));

  assert_imm_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && x_fld[OPND_W-1 -: 2] == 2'b11) |=> (out_x_kind == 3'd4));

  assert_two_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !x_fld[OPND_W-1] && !y_fld[OPND_W-1]) |=> (out_err_mem && out_error));

  assert_two_hw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && x_fld[OPND_W-1 -: 3] == 3'b100 && y_fld[OPND_W-1 -: 3] == 3'b100)
      |=> (out_err_hw && out_error));

  assert_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && y_fld[OPND_W-1 -: 6] == 6'b101110) |=> (out_err_enc && out_error));
endmodule

bind mc_operand_decoder mcod_chk #(.OPND_W(OPND_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .in_valid    (in_valid),
  .x_fld       (in_word[3*OPND_W-1 -: OPND_W]),
  .y_fld       (in_word[2*OPND_W-1 -: OPND_W]),
  .out_valid   (out_valid),
  .out_x_kind  (out_x_kind),
  .out_err_mem (out_err_mem),
  .out_err_hw  (out_err_hw),
  .out_err_enc (out_err_enc),
  .out_error   (out_error)
);

// File: tb/tb_mc_operand_decoder.sv
`timescale 1ns/1ps
module tb_mc_operand_decoder;
  localparam int W = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_word;
  logic [95:0] in_bases;
  logic        out_valid;
  logic [11:0] out_opcode;
  logic [2:0]  out_x_kind, out_y_kind;
  logic [15:0] out_x_val, out_y_val;
  logic [W-1:0] out_z_fld;
  logic        out_err_mem, out_err_hw, out_err_enc, out_error;

  always #2.5 clk = ~clk;

  mc_operand_decoder #(.OPND_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_bases(in_bases), .out_valid(out_valid), .out_opcode(out_opcode),
    .out_x_kind(out_x_kind), .out_x_val(out_x_val),
    .out_y_kind(out_y_kind), .out_y_val(out_y_val), .out_z_fld(out_z_fld),
    .out_err_mem(out_err_mem), .out_err_hw(out_err_hw),
    .out_err_enc(out_err_enc), .out_error(out_error)
  );

  typedef struct {
    string       tag;
    logic [11:0] opc;
    logic [2:0]  kx, ky;
    logic [15:0] vx, vy;
    logic [11:0] z;
    logic        em, eh, ee;
  } exp_t;

  exp_t        sb[$];
  int          n_tests = 0;
  int          n_fail  = 0;
  logic [15:0] bases [6];

  // Reference classification, written from the requirements
  task automatic classify(input logic [11:0] f, output logic [2:0] k, output logic [15:0] v);
    int iv;
    case (f[11:9])
      3'b000, 3'b001, 3'b010, 3'b011: begin k = 3'd0; v = {5'd0, f[10:0]}; end
      3'b110, 3'b111: begin
        iv = int'(f[9:0]);
        if (iv >= 512) iv = iv - 1024;
        k = 3'd4; v = 16'(iv);
      end
      3'b100: begin k = 3'd2; v = {7'd0, f[8:0]}; end
      default: begin
        if (f[8:6] <= 3'd5) begin k = 3'd1; v = 16'(bases[f[8:6]] + {10'd0, f[5:0]}); end
        else if (f[8:6] == 3'd7) begin k = 3'd3; v = {10'd0, f[5:0]}; end
        else begin k = 3'd5; v = 16'd0; end
      end
    endcase
  endtask

  function automatic logic is_mem(input logic [2:0] k);
    return (k == 3'd0) || (k == 3'd1);
  endfunction

  task automatic send(input string tag, input logic [63:0] w);
    exp_t e;
    e.tag = tag;
    e.opc = w[47:36];
    e.z   = w[11:0];
    classify(w[35:24], e.kx, e.vx);
    classify(w[23:12], e.ky, e.vy);
    e.em = is_mem(e.kx) && is_mem(e.ky);
    e.eh = (e.kx == 3'd2) && (e.ky == 3'd2);
    e.ee = (e.kx == 3'd5) || (e.ky == 3'd5) || (w[63:48] != 16'd0);
    @(negedge clk);
    for (int i = 0; i < 6; i++) in_bases[i*16 +: 16] = bases[i];
    in_valid = 1'b1;
    in_word  = w;
    sb.push_back(e);
  endtask

  task automatic check(input string tag, input logic ok, input string act, input string exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(tag, (out_valid === 1'b0) && (out_error === 1'b0) && (out_err_mem === 1'b0) &&
               (out_err_hw === 1'b0) && (out_err_enc === 1'b0),
          $sformatf("v=%b e=%b", out_valid, out_error), "v=0 e=0");
  endtask

  // Operand builders for 12-bit operands
  function automatic logic [11:0] o_dir(input logic [10:0] a);  return {1'b0, a}; endfunction
  function automatic logic [11:0] o_imm(input logic [9:0] v);   return {2'b11, v}; endfunction
  function automatic logic [11:0] o_hw(input logic [8:0] i);    return {3'b100, i}; endfunction
  function automatic logic [11:0] o_base(input logic [2:0] r, input logic [5:0] o);
    return {3'b101, r, o};
  endfunction
  function automatic logic [11:0] o_cpu(input logic [5:0] i);   return {6'b101111, i}; endfunction
  function automatic logic [63:0] mk(input logic [11:0] opc, input logic [11:0] x,
                                     input logic [11:0] y, input logic [11:0] z);
    return {16'h0000, opc, x, y, z};
  endfunction

  // Monitor: result due one edge after the strobe
  always @(negedge clk) begin
    if (rst_n && out_valid === 1'b1) begin
      if (sb.size() == 0) begin
        check("R9", 1'b0, "unexpected out_valid", "no result");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag,
              out_opcode == e.opc && out_z_fld == e.z &&
              out_x_kind == e.kx && out_x_val == e.vx &&
              out_y_kind == e.ky && out_y_val == e.vy &&
              out_err_mem == e.em && out_err_hw == e.eh && out_err_enc == e.ee &&
              out_error == (e.em | e.eh | e.ee),
              $sformatf("op=%h x=%0d/%h y=%0d/%h z=%h m%b h%b e%b any%b", out_opcode,
                        out_x_kind, out_x_val, out_y_kind, out_y_val, out_z_fld,
                        out_err_mem, out_err_hw, out_err_enc, out_error),
              $sformatf("op=%h x=%0d/%h y=%0d/%h z=%h m%b h%b e%b", e.opc,
                        e.kx, e.vx, e.ky, e.vy, e.z, e.em, e.eh, e.ee));
      end
    end
  end

  initial begin
    #(100000 * 5);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_word  = '0;
    in_bases = '0;
    for (int i = 0; i < 6; i++) bases[i] = 16'h1000 * 16'(i + 1) + 16'(i);
    bases[5] = 16'hFFF0;
    repeat (3) @(negedge clk);
    check("R10", out_valid === 1'b0 && out_error === 1'b0 && out_err_mem === 1'b0,
          $sformatf("v=%b e=%b", out_valid, out_error), "v=0 e=0");
    in_valid = 1'b1;
    @(negedge clk);
    check("R10", out_valid === 1'b0 && out_error === 1'b0,
          $sformatf("v=%b e=%b", out_valid, out_error), "v=0 e=0");
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", out_valid === 1'b0 && out_error === 1'b0,
          $sformatf("v=%b e=%b", out_valid, out_error), "v=0 e=0");

    // Back-to-back burst
    send("R1_R2", mk(12'h1C3, o_dir(11'h001), o_imm(10'd5), 12'h123));
    send("R3",    mk(12'h130, o_imm(10'h3FF), o_imm(10'h200), 12'h000));
    send("R2_R3", mk(12'h160, o_imm(10'h1FF), o_dir(11'h7FF), 12'h7FF));
    send("R5",    mk(12'h1C0, o_base(3'd0, 6'h3F), o_imm(10'd1), 12'h001));
    send("R4_R5", mk(12'h1D0, o_base(3'd5, 6'h20), o_hw(9'h1FF), 12'h002));
    send("R6",    mk(12'h170, o_cpu(6'h3F), o_cpu(6'h00), 12'hFFF));
    idle_check("R9");

    send("R7",    mk(12'h140, o_dir(11'h010), o_dir(11'h020), 12'h003));
    send("R7",    mk(12'h150, o_base(3'd3, 6'h01), o_dir(11'h004), 12'h004));
    send("R8",    mk(12'h110, o_hw(9'h001), o_hw(9'h002), 12'h005));
    send("R6",    mk(12'h120, o_imm(10'd7), {6'b101110, 6'h2A}, 12'h006));
    send("R6",    {16'h8000, 12'h1A0, o_imm(10'd2), o_cpu(6'd4), 12'h007});
    send("R4",    mk(12'h101, o_hw(9'h0AB), o_dir(11'h321), 12'h008));
    send("R1",    mk(12'hFFF, o_cpu(6'd1), o_imm(10'd0), 12'hABC));
    idle_check("R9");

    bases[2] = 16'h00FF;
    send("R5",    mk(12'h1C1, o_base(3'd2, 6'h01), o_base(3'd4, 6'h3F), 12'h009));
    send("R2_R5", mk(12'h1C2, o_imm(10'd3), o_base(3'd1, 6'h00), 12'h00A));
    idle_check("R9");

    repeat (3) @(negedge clk);
    check("R9", sb.size() == 0, $sformatf("%0d pending", sb.size()), "0 pending");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule